// File: doc/BRIEF.md
# Buffered Word-Program Loader

This block accepts a short command sequence from a host and uses it to program a run of up to 32 words into a word-programmable array. The sequence has four parts. A setup write names the target block. A count write follows, then the data words at consecutive addresses starting on a 32-word boundary, and last a confirm write. The loader checks each step as it arrives and collects the words in a small buffer RAM. It then writes them into the array one at a time, each taking a fixed number of cycles. Programming can only clear bits, so every array write is an AND of the old word and the new word.

A second entry path, the fill mode, always takes a full buffer of 32 words and needs neither a count nor a confirm. Programming starts as soon as the last word lands. The host must pad the words it does not need with 0xFFFF, because all-ones leaves the array unchanged.

A one-byte status output tells the host when the loader is busy and whether the last sequence was rejected. A separate read port gives the array contents after one cycle of latency.

Top module: `wbuf_prog`

## Requirements
- R1: After a synchronous reset the status output is 0x80: bit 7 (ready) is 1 and error bits 5 and 4 are 0.
- R2: In idle, a write whose data low byte is 0xE8 opens a buffered load. The target window is the write address with its low 5 bits cleared. The write clears status bits 5 and 4, and bit 7 stays 1 while the buffer is being loaded.
- R3: The write after setup carries the word count minus one. A value from 0 to 31 is accepted. A larger value sets status bits 5 and 4 and returns the loader to idle.
- R4: The data words must target the window start and then consecutive addresses. Any other address sets status bits 5 and 4, abandons the load and leaves the array unchanged.
- R5: After the last data word, a write whose low byte is 0xD0 starts programming. Any other value sets status bits 5 and 4 and leaves the array unchanged.
- R6: Status bit 7 is 0 for exactly N x PROG_CYCLES cycles, counted from the clock edge that starts programming, where N is the number of words. It then returns to 1.
- R7: Word i of the buffer is ANDed into array address window+i, so bits only change from 1 to 0. Addresses outside the N programmed words are not touched.
- R8: In idle, a write whose low byte is 0x80 opens fill mode. It clears the error bits and takes exactly 32 consecutive words from the window start. Programming starts on the edge that takes the 32nd word, with no count and no confirm.
- R9: Host writes made while status bit 7 is 0 have no effect on the sequence.
- R10: The array read port returns the word at rd_addr one clock edge after the address is applied. Every array word starts as 0xFFFF.
- R11: In idle, writes whose low byte is neither 0xE8 nor 0x80 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data or command code |
| status | output | 8 | Bit 7 ready, bits 5 and 4 error, other bits 0 |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data, one cycle latency |

## Verification
The buffered path is run with a one-word count, a partial count and a full count. A second pass over the same window separates an AND into the array from a plain overwrite. Fill mode is run with padding words, which shows that all-ones words leave the array as it was. The three rejection paths are exercised next: an oversized count, a skipped address and a wrong confirm. Each is followed by array reads, which separate a clean abort from a partial write. A setup code sent while busy is followed after completion by a value that would be an illegal count, which shows whether that setup code was wrongly accepted.

// File: rtl/wbuf_prog_pkg.sv
package wbuf_prog_pkg;
  localparam logic [7:0] CMD_LOAD = 8'hE8;
  localparam logic [7:0] CMD_FILL = 8'h80;
  localparam logic [7:0] CMD_GO   = 8'hD0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COUNT, ST_LOAD, ST_CONFIRM, ST_FILL, ST_PROG
  } wbp_state_e;
endpackage

// File: rtl/wbuf_prog_sdpram.sv
module wbuf_prog_sdpram #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wbuf_prog_array.sv
module wbuf_prog_array #(
  parameter int W      = 16,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] cells [DEPTH];

  // erased array: every cell starts all-ones
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= cells[waddr] & wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/wbuf_prog_ctrl.sv
module wbuf_prog_ctrl
  import wbuf_prog_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int BUF_WORDS   = 32,
  parameter int PROG_CYCLES = 4,
  localparam int BUF_AW     = $clog2(BUF_WORDS),
  localparam int HI_W       = ADDR_W - BUF_AW,
  localparam int DLY_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        status,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam logic [BUF_AW-1:0] LAST_SLOT = BUF_AW'(BUF_WORDS - 1);
  localparam logic [DLY_W-1:0]  LAST_DLY  = DLY_W'(PROG_CYCLES - 1);

  wbp_state_e        st, st_n;
  logic [HI_W-1:0]   base_hi;
  logic [BUF_AW-1:0] idx, last_idx;
  logic [DLY_W-1:0]  dly;
  logic              err_q, ready_q;

  logic is_load_cmd, is_fill_cmd, is_go, too_big, addr_hit, step_done, err_set, err_clr;

  always_comb begin
    is_load_cmd = (wr_data[7:0] == CMD_LOAD);
    is_fill_cmd = (wr_data[7:0] == CMD_FILL);
    is_go       = (wr_data[7:0] == CMD_GO);
    too_big     = (wr_data > DATA_W'(BUF_WORDS - 1));
    addr_hit    = (wr_addr == {base_hi, idx});
    step_done   = (st == ST_PROG) && (dly == LAST_DLY);

    buf_we    = wr_en && addr_hit && (st == ST_LOAD || st == ST_FILL);
    buf_waddr = idx;
    buf_wdata = wr_data;
    buf_raddr = idx;

    arr_we    = step_done;
    arr_waddr = {base_hi, idx};
    arr_wdata = buf_rdata;

    err_clr = (st == ST_IDLE) && wr_en && (is_load_cmd || is_fill_cmd);
    err_set = wr_en && (((st == ST_COUNT) && too_big) ||
                        ((st == ST_LOAD || st == ST_FILL) && !addr_hit) ||
                        ((st == ST_CONFIRM) && !is_go));

    st_n = st;
    unique case (st)
      ST_IDLE: begin
        if (wr_en && is_load_cmd)      st_n = ST_COUNT;
        else if (wr_en && is_fill_cmd) st_n = ST_FILL;
      end
      ST_COUNT:   if (wr_en) st_n = too_big ? ST_IDLE : ST_LOAD;
      ST_LOAD: begin
        if (wr_en && !addr_hit)                st_n = ST_IDLE;
        else if (wr_en && (idx == last_idx))   st_n = ST_CONFIRM;
      end
      ST_CONFIRM: if (wr_en) st_n = is_go ? ST_PROG : ST_IDLE;
      ST_FILL: begin
        if (wr_en && !addr_hit)                st_n = ST_IDLE;
        else if (wr_en && (idx == last_idx))   st_n = ST_PROG;
      end
      ST_PROG:    if (step_done && (idx == last_idx)) st_n = ST_IDLE;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ready_q  <= 1'b1;
      err_q    <= 1'b0;
      base_hi  <= '0;
      idx      <= '0;
      last_idx <= '0;
      dly      <= '0;
    end else begin
      st      <= st_n;
      ready_q <= (st_n != ST_PROG);
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;

      unique case (st)
        ST_IDLE: if (err_clr) begin
          base_hi <= wr_addr[ADDR_W-1:BUF_AW];
          idx     <= '0;
          if (is_fill_cmd) last_idx <= LAST_SLOT;
        end
        ST_COUNT: if (wr_en) last_idx <= wr_data[BUF_AW-1:0];
        ST_LOAD, ST_FILL: begin
          dly <= '0;
          if (buf_we) idx <= (idx == last_idx) ? '0 : idx + 1'b1;
        end
        ST_PROG: begin
          if (step_done) begin
            dly <= '0;
            idx <= idx + 1'b1;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign status = {ready_q, 1'b0, err_q, err_q, 4'b0000};
endmodule

// File: rtl/wbuf_prog.sv
module wbuf_prog #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int BUF_WORDS   = 32,
  parameter int PROG_CYCLES = 4,
  localparam int BUF_AW     = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        status,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic              buf_we, arr_we;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [DATA_W-1:0] buf_wdata, buf_rdata, arr_wdata;
  logic [ADDR_W-1:0] arr_waddr;

  wbuf_prog_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status(status), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  wbuf_prog_sdpram #(.W(DATA_W), .DEPTH(BUF_WORDS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  wbuf_prog_array #(.W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/wbuf_prog_chk.sv
module wbuf_prog_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] status,
  input logic       arr_we
);
  // R6
  arr_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !status[7]);

  // R6
  busy_end_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[7]) |-> $past(arr_we));

  // R5
  start_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[7]) |-> (status[5:4] == 2'b00));

  // R9
  err_stable_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !status[7] |-> $stable(status[5:4]));

  // R7
  write_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> !arr_we);

  // R3
  err_from_host_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> $past(wr_en));
endmodule

bind wbuf_prog wbuf_prog_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .status(status), .arr_we(arr_we)
);

// File: tb/wbuf_prog_bench.sv
`timescale 1ns/1ps
module wbuf_prog_bench;
  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  status;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  wbuf_prog #(.DATA_W(16), .ADDR_W(8), .BUF_WORDS(32), .PROG_CYCLES(DLY)) u_wbuf_prog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status(status), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: 0 idle, 1 count, 2 load, 3 confirm, 4 fill, 5 program
  logic [15:0] marr [256];
  logic [15:0] q [$];
  int  mst = 0, mbase = 0, mn = 0, busy = 0;
  bit  merr = 0;

  function automatic logic [15:0] word_of(input logic [15:0] seed, input int i);
    return seed ^ 16'(i * 4919) ^ 16'(1 << (i % 16));
  endfunction

  task automatic commit();
    for (int i = 0; i < q.size(); i++) marr[mbase + i] = marr[mbase + i] & q[i];
    busy = q.size() * DLY;
    mst  = 5;
  endtask

  task automatic model(input bit we, input logic [7:0] a, input logic [15:0] d);
    case (mst)
      0: if (we && (d[7:0] == 8'hE8 || d[7:0] == 8'h80)) begin
           mbase = int'(a) & ~31; merr = 0; q.delete();
           if (d[7:0] == 8'hE8) mst = 1; else begin mn = 32; mst = 4; end
         end
      1: if (we) begin
           if (d > 16'd31) begin merr = 1; mst = 0; end
           else begin mn = int'(d) + 1; mst = 2; end
         end
      2, 4: if (we) begin
           if (int'(a) != mbase + q.size()) begin merr = 1; mst = 0; end
           else begin
             q.push_back(d);
             if (q.size() == mn) begin
               if (mst == 2) mst = 3; else commit();
             end
           end
         end
      3: if (we) begin
           if (d[7:0] == 8'hD0) commit();
           else begin merr = 1; mst = 0; end
         end
      5: begin busy--; if (busy == 0) mst = 0; end
      default: mst = 0;
    endcase
  endtask

  task automatic check(input bit ok, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h expected %h", what, got, exp);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [15:0] d, input string tag);
    logic [7:0] es;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    es = {(mst != 5), 1'b0, merr, merr, 4'b0};
    check(status == es, {tag, " status"}, {8'h0, status}, {8'h0, es});
  endtask

  task automatic drain(input string tag);
    while (mst == 5) step(0, 8'h0, 16'h0, tag);
    step(0, 8'h0, 16'h0, tag);
  endtask

  task automatic check_window(input int base, input string tag);
    for (int i = 0; i < 33; i++) begin
      rd_addr = 8'(base + i);
      @(posedge clk);
      model(0, 8'h0, 16'h0);
      @(negedge clk);
      check(rd_data == marr[8'(base + i)], {tag, " array word"}, rd_data, marr[8'(base + i)]);
    end
  endtask

  task automatic buffered(input logic [7:0] sa, input int n, input logic [15:0] seed, input string tag);
    int b;
    b = int'(sa) & ~31;
    step(1, sa, 16'h00E8, "R2");
    step(1, sa, 16'(n - 1), "R3");
    for (int i = 0; i < n; i++) step(1, 8'(b + i), word_of(seed, i), "R4");
    step(1, sa, 16'h00D0, "R5");
    drain({tag, " R6"});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) marr[i] = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(status == 8'h80, "R1 reset status", {8'h0, status}, 16'h0080);

    // R11: idle writes with no setup code
    step(1, 8'h10, 16'h1234, "R11");
    step(1, 8'h11, 16'h00D0, "R11");
    step(0, 8'h0, 16'h0, "R11");

    // partial count, misaligned setup address
    buffered(8'h25, 4, 16'hA5C3, "R7");
    check_window(32, "R7/R10");
    // AND over the same window
    buffered(8'h20, 6, 16'h0F0F, "R7");
    check_window(32, "R7");
    // single word and full buffer
    buffered(8'h00, 1, 16'h1111, "R6");
    check_window(0, "R7");
    buffered(8'h5F, 32, 16'h3C3C, "R6");
    check_window(64, "R7");

    // R3: oversized count
    step(1, 8'hC0, 16'h00E8, "R2");
    step(1, 8'hC0, 16'd32, "R3");
    check(status[5:4] == 2'b11, "R3 error bits", {14'h0, status[5:4]}, 16'h3);
    step(1, 8'hC0, 16'h0000, "R3");
    check_window(192, "R3");

    // R4: skipped address
    step(1, 8'hC0, 16'h00E8, "R2");
    step(1, 8'hC0, 16'd3, "R3");
    step(1, 8'hC0, 16'h0000, "R4");
    step(1, 8'hC2, 16'h0000, "R4");
    check(status[5:4] == 2'b11, "R4 error bits", {14'h0, status[5:4]}, 16'h3);
    check_window(192, "R4");

    // R5: wrong confirm
    step(1, 8'hC0, 16'h00E8, "R2");
    check(status == 8'h80, "R2 error cleared", {8'h0, status}, 16'h0080);
    step(1, 8'hC0, 16'd1, "R3");
    step(1, 8'hC0, 16'h0000, "R4");
    step(1, 8'hC1, 16'h0000, "R4");
    step(1, 8'hC0, 16'h00D1, "R5");
    check(status[5:4] == 2'b11, "R5 error bits", {14'h0, status[5:4]}, 16'h3);
    check_window(192, "R5");

    // R8: fill mode with all-ones padding, R9: setup during busy ignored
    step(1, 8'h8A, 16'h0080, "R8");
    check(status == 8'h80, "R8 fill open", {8'h0, status}, 16'h0080);
    for (int i = 0; i < 32; i++)
      step(1, 8'(128 + i), (i < 20) ? word_of(16'h5A5A, i) : 16'hFFFF, "R8");
    check(status[7] == 1'b0, "R8 busy after 32nd word", {15'h0, status[7]}, 16'h0);
    step(1, 8'h40, 16'h00E8, "R9");
    drain("R8 R6");
    step(1, 8'h40, 16'h00D0, "R9");
    check(status == 8'h80, "R9 busy write ignored", {8'h0, status}, 16'h0080);
    check_window(128, "R8");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog got hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule